// File: doc/BRIEF.md
# Host Interrupt Controller with Masking

This block gathers single-cycle event strobes from the internal logic of a wireless MAC and drives one interrupt line toward the host. Each event sets a sticky pending bit. A mask register decides which pending bits may reach the line, and a 1 in a mask bit blocks its source. Software can rewrite the mask in one write. It can also change chosen mask bits through a write-only set port and a write-only clear port, so it never needs a read-modify-write.

Pending bits can be read in two ways. A peek read leaves them unchanged. A take read returns them and then clears every one. A write-one acknowledge port clears chosen bits. Two configuration bits enable the line and select its polarity. All access goes through a simple register bus with separate write and read strobes. Read data is registered and appears one cycle after the read strobe.

Source bit positions: 0 first receive buffer, 1 transmit data, 2 transmit transfer, 3 second receive buffer, 4 receive transfer, 5 and 6 event mailbox, 7 wake, 8 and 9 debug trace, 10 command complete, 14 initialization complete, 16 and 17 coexistence sense enable and disable. No other bit position carries a source.

Top module: `hostirq_ctrl`

## Requirements
- R1: After reset the mask reads 0x0000_0001, no bit is pending, the configuration register reads 0, and `host_irq` is 0.
- R2: A 1 on `evt_in` at a source bit position (0-10, 14, 16, 17) sets that pending bit, and the bit stays set with no further events. Strobes at all other positions are ignored, and those positions always read 0.
- R3: A write to address 0 loads the mask directly with the source bits of the write data. Address 0 reads back the mask, with non-source bits as 0.
- R4: A write to address 1 sets every mask bit written as 1 and leaves the other mask bits as they were.
- R5: A write to address 2 clears every mask bit written as 1 and leaves the other mask bits as they were.
- R6: A read of address 3 returns the pending bits on `bus_rdata` one cycle after the read strobe and leaves them unchanged.
- R7: A read of address 4 returns the pending bits one cycle after the strobe and then clears all of them. An event that arrives in the same cycle as the read stays pending.
- R8: A write to address 5 clears the pending bits written as 1, and bits written as 0 have no effect. An event that arrives in the same cycle as the clear keeps its bit pending.
- R9: Configuration register (address 6): bit 0 enables the line and bit 1 selects active-low. With the line enabled and active-high, `host_irq` is 1 exactly when some pending bit is unmasked. The line follows a change of pending, mask or configuration one cycle after the register update.
- R10: With bit 0 clear, `host_irq` holds its inactive level, which is 0 for active-high and 1 for active-low. With bit 1 set, the enabled line is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | DATA_W | Single-cycle event strobes, one per source |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| host_irq | output | 1 | Host interrupt line |

## Verification
A write or an event changes the mask, configuration or pending state at the clock edge where it is sampled. Read data is due one edge after the read strobe. The registered interrupt line is due one edge after the state change. The bench drives every input on the falling edge. Its monitor records whether a read strobe was present at each rising edge and compares the queued expectation at the following falling edge. Each interrupt-line check waits one extra rising edge after the stimulus before it samples, and no other stimulus is applied in between.

// File: rtl/hostirq_pkg.sv
package hostirq_pkg;
   // word addresses of the register map
   localparam int REG_MASK  = 0;
   localparam int REG_SET   = 1;
   localparam int REG_CLR   = 2;
   localparam int REG_PEEK  = 3;
   localparam int REG_TAKE  = 4;
   localparam int REG_ACK   = 5;
   localparam int REG_CFG   = 6;
   localparam int REG_COUNT = 7;

   // configuration register bit positions
   localparam int CFG_EN_BIT  = 0;
   localparam int CFG_LOW_BIT = 1;

   typedef struct packed {
      logic wr_mask;
      logic wr_set;
      logic wr_clr;
      logic wr_ack;
      logic wr_cfg;
      logic rd_take;
   } hostirq_strobe_t;
endpackage

// File: rtl/hostirq_regif.sv
module hostirq_regif
   import hostirq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic [DATA_W-1:0]   pend_q,
   input  logic [DATA_W-1:0]   mask_q,
   output hostirq_strobe_t     strb,
   output logic                cfg_en,
   output logic                cfg_low,
   output logic [DATA_W-1:0]   bus_rdata
);
   localparam int CFG_W = 2;

   logic [REG_COUNT-1:0] hit;
   logic [CFG_W-1:0]     cfg_q;
   logic [DATA_W-1:0]    rd_mux;

   for (genvar r = 0; r < REG_COUNT; r++) begin : g_hit
      assign hit[r] = (bus_addr == ADDR_W'(r));
   end

   always_comb begin
      strb.wr_mask = bus_wr & hit[REG_MASK];
      strb.wr_set  = bus_wr & hit[REG_SET];
      strb.wr_clr  = bus_wr & hit[REG_CLR];
      strb.wr_ack  = bus_wr & hit[REG_ACK];
      strb.wr_cfg  = bus_wr & hit[REG_CFG];
      strb.rd_take = bus_rd & hit[REG_TAKE];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (strb.wr_cfg) begin
         cfg_q <= bus_wdata[CFG_W-1:0];
      end
   end

   assign cfg_en  = cfg_q[CFG_EN_BIT];
   assign cfg_low = cfg_q[CFG_LOW_BIT];

   always_comb begin
      rd_mux = '0;
      if (hit[REG_MASK]) rd_mux = mask_q;
      if (hit[REG_PEEK] || hit[REG_TAKE]) rd_mux = pend_q;
      if (hit[REG_CFG]) rd_mux = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/hostirq_mask.sv
module hostirq_mask
   import hostirq_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter logic [DATA_W-1:0] SRC_VALID = 32'h0003_47FF,
   parameter logic [DATA_W-1:0] MASK_RST  = 32'h0000_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  hostirq_strobe_t   strb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask_q
);
   logic [DATA_W-1:0] mask_d;

   always_comb begin
      mask_d = mask_q;
      if (strb.wr_mask) mask_d = wdata;
      if (strb.wr_set)  mask_d = mask_q | wdata;
      if (strb.wr_clr)  mask_d = mask_q & ~wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= MASK_RST & SRC_VALID;
      end else begin
         mask_q <= mask_d & SRC_VALID;
      end
   end
endmodule

// File: rtl/hostirq_pending.sv
module hostirq_pending
   import hostirq_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter logic [DATA_W-1:0] SRC_VALID = 32'h0003_47FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  hostirq_strobe_t   strb,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] evt_in,
   output logic [DATA_W-1:0] pend_q
);
   logic [DATA_W-1:0] drop;
   logic [DATA_W-1:0] pend_d;

   always_comb begin
      drop = '0;
      if (strb.wr_ack)  drop = drop | wdata;
      if (strb.rd_take) drop = '1;
      // a new event wins over any clear in the same cycle
      pend_d = ((pend_q & ~drop) | evt_in) & SRC_VALID;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         pend_q <= pend_d;
      end
   end
endmodule

// File: rtl/hostirq_outdrv.sv
module hostirq_outdrv #(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pend_q,
   input  logic [DATA_W-1:0] mask_q,
   input  logic              cfg_en,
   input  logic              cfg_low,
   output logic              host_irq
);
   logic raw;
   logic line_d;

   assign raw    = |(pend_q & ~mask_q);
   assign line_d = (raw & cfg_en) ^ cfg_low;

   if (OUT_REG) begin : g_flop
      logic line_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            line_q <= 1'b0;
         end else begin
            line_q <= line_d;
         end
      end
      assign host_irq = line_q;
   end else begin : g_comb
      assign host_irq = line_d;
   end
endmodule

// File: rtl/hostirq_ctrl.sv
module hostirq_ctrl
   import hostirq_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                ADDR_W    = 3,
   parameter logic [DATA_W-1:0] SRC_VALID = 32'h0003_47FF,
   parameter logic [DATA_W-1:0] MASK_RST  = 32'h0000_0001,
   parameter bit                OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              host_irq
);
   localparam int MIN_ADDR_W = $clog2(REG_COUNT);

   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("hostirq_ctrl: ADDR_W too small for the register map");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("hostirq_ctrl: DATA_W must hold the configuration bits");
   end
   if ((MASK_RST & ~SRC_VALID) != '0) begin : g_bad_rst
      $error("hostirq_ctrl: MASK_RST names a non-source bit");
   end

   hostirq_strobe_t   strb;
   logic [DATA_W-1:0] pend_q;
   logic [DATA_W-1:0] mask_q;
   logic              cfg_en;
   logic              cfg_low;

   hostirq_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .pend_q(pend_q),
      .mask_q(mask_q), .strb(strb), .cfg_en(cfg_en), .cfg_low(cfg_low),
      .bus_rdata(bus_rdata)
   );

   hostirq_mask #(.DATA_W(DATA_W), .SRC_VALID(SRC_VALID), .MASK_RST(MASK_RST)) u_mask (
      .clk(clk), .rst_n(rst_n), .strb(strb), .wdata(bus_wdata), .mask_q(mask_q)
   );

   hostirq_pending #(.DATA_W(DATA_W), .SRC_VALID(SRC_VALID)) u_pend (
      .clk(clk), .rst_n(rst_n), .strb(strb), .wdata(bus_wdata),
      .evt_in(evt_in), .pend_q(pend_q)
   );

   hostirq_outdrv #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
      .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .mask_q(mask_q),
      .cfg_en(cfg_en), .cfg_low(cfg_low), .host_irq(host_irq)
   );
endmodule

// File: rtl/hostirq_chk.sv
module hostirq_chk
   import hostirq_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                ADDR_W    = 3,
   parameter logic [DATA_W-1:0] SRC_VALID = 32'h0003_47FF,
   parameter bit                OUT_REG   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] evt_in,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              host_irq,
   input logic [DATA_W-1:0] pend,
   input logic [DATA_W-1:0] mask,
   input logic              cfg_en,
   input logic              cfg_low
);
   // R2: a source event is pending in the next cycle
   assert_event_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_in & SRC_VALID)) |=> ((pend & $past(evt_in & SRC_VALID)) == $past(evt_in & SRC_VALID)));

   // R3: non-source mask bits never hold a 1
   assert_mask_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mask & ~SRC_VALID) == '0);

   assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(REG_SET))
      |=> ((mask & $past(bus_wdata & SRC_VALID)) == $past(bus_wdata & SRC_VALID)));

   assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(REG_CLR)) |=> ((mask & $past(bus_wdata)) == '0));

   assert_peek_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(REG_PEEK)) |=> (bus_rdata == $past(pend) && pend == ($past(pend) | $past(evt_in & SRC_VALID))));

   assert_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(REG_TAKE)) |=> (pend == $past(evt_in & SRC_VALID)));

   if (OUT_REG) begin : g_line
      assert_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
         host_irq == ((($past(|(pend & ~mask))) & $past(cfg_en)) ^ $past(cfg_low)));
   end
endmodule

bind hostirq_ctrl hostirq_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_VALID(SRC_VALID), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_addr(bus_addr),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .host_irq(host_irq), .pend(pend_q),
   .mask(mask_q), .cfg_en(cfg_en), .cfg_low(cfg_low)
);

// File: tb/test_hostirq_ctrl.sv
`timescale 1ns/1ps
module test_hostirq_ctrl;
   localparam int DW = 32;
   localparam int AW = 3;
   localparam logic [2:0] A_MASK = 3'd0, A_SET = 3'd1, A_CLR = 3'd2,
                          A_PEEK = 3'd3, A_TAKE = 3'd4, A_ACK = 3'd5, A_CFG = 3'd6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] evt_in = '0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          host_irq;

   int checks = 0;
   int failures = 0;
   logic [DW-1:0] exp_q[$];
   string         tag_q[$];

   always #2 clk = ~clk;

   hostirq_ctrl i_hostirq_ctrl (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .host_irq(host_irq)
   );

   // monitor: read data is due one edge after the strobe
   initial begin
      forever begin
         logic took;
         @(posedge clk);
         took = bus_rd & rst_n;
         @(negedge clk);
         if (took && exp_q.size() > 0) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
               failures++;
               $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic bus_op(input logic w, input logic r, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [DW-1:0] ev);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; evt_in = ev;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; evt_in = '0;
   endtask

   task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_op(1'b1, 1'b0, a, d, '0);
   endtask

   task automatic do_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      bus_op(1'b0, 1'b1, a, '0, '0);
   endtask

   task automatic pulse(input logic [DW-1:0] ev);
      bus_op(1'b0, 1'b0, '0, '0, ev);
   endtask

   // the registered line follows state one edge later
   task automatic irq_chk(input logic e, input string t);
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (host_irq !== e) begin
         failures++;
         $display("FAIL %s host_irq actual=%b expected=%b", t, host_irq, e);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      checks++;
      if (host_irq !== 1'b0) begin
         failures++;
         $display("FAIL R1 host_irq actual=%b expected=0", host_irq);
      end
      do_rd(A_MASK, 32'h0000_0001, "R1 mask");
      do_rd(A_PEEK, 32'h0, "R1 pending");
      do_rd(A_CFG, 32'h0, "R1 cfg");

      // R2, R9: masked source stays off the line
      do_wr(A_CFG, 32'h1);
      pulse(32'h0000_0001);
      irq_chk(1'b0, "R9 masked source");
      do_rd(A_PEEK, 32'h0000_0001, "R2 single event");
      pulse(32'hFFFF_FFFF);
      do_rd(A_PEEK, 32'h0003_47FF, "R2 reserved ignored");
      irq_chk(1'b1, "R9 unmasked pending");
      do_rd(A_PEEK, 32'h0003_47FF, "R6 peek keeps");

      // R7: take clears all
      do_rd(A_TAKE, 32'h0003_47FF, "R7 take value");
      do_rd(A_PEEK, 32'h0, "R7 cleared");
      irq_chk(1'b0, "R9 nothing pending");

      // R3, R4, R5
      do_wr(A_MASK, 32'hFFFF_FFFF);
      do_rd(A_MASK, 32'h0003_47FF, "R3 direct write");
      do_wr(A_CLR, 32'h0000_0402);
      do_rd(A_MASK, 32'h0003_43FD, "R5 clear bits");
      do_wr(A_SET, 32'h0000_0400);
      do_rd(A_MASK, 32'h0003_47FD, "R4 set bits");

      // R8: acknowledge
      pulse(32'h0000_0002);
      irq_chk(1'b1, "R9 bit1 unmasked");
      pulse(32'h0000_0400);
      do_rd(A_PEEK, 32'h0000_0402, "R8 before ack");
      do_wr(A_ACK, 32'h0000_0400);
      do_rd(A_PEEK, 32'h0000_0002, "R8 ack one bit");
      do_wr(A_ACK, 32'h0);
      do_rd(A_PEEK, 32'h0000_0002, "R8 zero ack no effect");

      // R10: polarity and enable
      do_wr(A_CFG, 32'h3);
      irq_chk(1'b0, "R10 active-low asserted");
      do_wr(A_CFG, 32'h2);
      irq_chk(1'b1, "R10 disabled active-low idle");
      do_wr(A_CFG, 32'h0);
      irq_chk(1'b0, "R10 disabled active-high idle");
      do_wr(A_CFG, 32'h1);
      irq_chk(1'b1, "R10 re-enabled");

      // R8: event with ack in the same cycle stays pending
      bus_op(1'b1, 1'b0, A_ACK, 32'h0000_0002, 32'h0000_0002);
      do_rd(A_PEEK, 32'h0000_0002, "R8 event beats ack");
      // R7: event with take in the same cycle stays pending
      exp_q.push_back(32'h0000_0002);
      tag_q.push_back("R7 take with event value");
      bus_op(1'b0, 1'b1, A_TAKE, '0, 32'h0000_4000);
      do_rd(A_PEEK, 32'h0000_4000, "R7 event beats take");
      do_wr(A_ACK, 32'hFFFF_FFFF);
      do_rd(A_PEEK, 32'h0, "R8 ack all");
      irq_chk(1'b0, "R9 cleared line");

      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule